// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Alarm

This block is a register-mapped real-time clock. A 32-bit seconds count advances once per second. The second tick comes from a prescaler that counts pulses on a clock-enable input and fires once every `DIV` pulses. A 32-bit alarm compare value raises an alarm event when the count reaches it. Two event flags, each with its own interrupt enable, drive one level interrupt output.

Software reaches the block through a single-cycle register port with a 2-bit word address. Reads are combinational. A write is latched into a commit stage and takes effect `COMMIT_CYCLES` clock cycles later. A ready bit in the control register is low while a write is in flight, so software polls it before each write. Writes that arrive while ready is low are dropped. Each stored value changes only at a single clock edge, so two back-to-back reads always agree unless a tick or a commit falls between them.

Top module: `sec_rtc`

## Requirements
- R1: After reset, the control register (word 0) reads 0x80 and the seconds, alarm and trim registers read 0. `irq_o` is low.
- R2: A write is accepted only while ready (control bit 7) is 1. Ready then reads 0 for exactly `COMMIT_CYCLES` cycles, and the written value is visible in the first cycle that ready is 1 again.
- R3: A write presented while ready is 0 has no effect on any register.
- R4: The word addresses are 0 for control, 1 for seconds, 2 for alarm and 3 for trim. Seconds, alarm and trim read back all 32 written bits. In control, the written bits 5, 3, 2 and 0 read back, and bits 31:8 and bit 1 read 0.
- R5: While the counter enable (control bit 0) is 1, every `DIV`-th pulse of `tick_en_i` is a tick. A tick adds one to the seconds count, modulo 2^32. While bit 0 is 0, the count and the prescaler phase hold.
- R6: The second flag (control bit 6) sets on every tick. A control write with bit 6 at 0 clears it and a write with bit 6 at 1 leaves it as it is. If a tick and a clearing write land on the same edge, the flag stays set.
- R7: The alarm flag (control bit 4) sets on a tick whose new count equals the alarm register, but only when the alarm enable (control bit 2) is 1. It is cleared by writing 0 in the same way as R6.
- R8: `irq_o` is high exactly when (bit 6 and bit 5) or (bit 4 and bit 3) are set in control. Both sources may be pending together.
- R9: A committed write to the seconds register sets the prescaler phase to zero and suppresses any tick on that edge.
- R10: The seconds register changes only on a tick or on a committed write to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Clock-enable pulse counted by the prescaler |
| addr_i | input | 2 | Word address for read and write |
| wr_i | input | 1 | Write request |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that `wr_i`, `addr_i` and `wdata_i` are stable around each rising edge and that `tick_en_i` is a plain level, sampled once per cycle. The bench drives every input on the falling edge and samples outputs one time unit later. It holds `tick_en_i` low while writes are in flight, so each tick lands where the expected count says it should. The only cycles where a write and a tick overlap are the ones R9 arranges on purpose. The prescaler divide is shrunk to 4 so that several ticks, a 32-bit wrap and an alarm hit all fit in a short run.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DW = 32;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_SEC  = 2'd1,
    A_ALM  = 2'd2,
    A_TRIM = 2'd3
  } rtc_addr_e;

  // control field positions (software visible)
  localparam int B_RDY   = 7;
  localparam int B_HZ_F  = 6;
  localparam int B_HZ_IE = 5;
  localparam int B_AL_F  = 4;
  localparam int B_AL_IE = 3;
  localparam int B_AL_EN = 2;
  localparam int B_RUN   = 0;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && en_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (run_i && en_i)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  p_phase_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));

  p_phase_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_wr_commit.sv
module rtc_wr_commit #(
  parameter int LAT = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic        ready_o,
  output logic        commit_o,
  output logic [1:0]  c_addr_o,
  output logic [31:0] c_data_o
);
  localparam int CW = $clog2(LAT + 1);

  logic          busy_q;
  logic [CW-1:0] left_q;
  logic          accept;

  assign ready_o  = !busy_q;
  assign accept   = wr_i && !busy_q;
  assign commit_o = busy_q && (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      left_q   <= '0;
      c_addr_o <= '0;
      c_data_o <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      left_q   <= CW'(LAT - 1);
      c_addr_o <= addr_i;
      c_data_o <= wdata_i;
    end else if (busy_q) begin
      if (left_q == '0) busy_q <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end

  p_accept_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !ready_o);

  p_busy_write_dropped_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !ready_o) |=> ($stable(c_addr_o) && $stable(c_data_o)));
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          commit_i,
  input  logic [1:0]    c_addr_i,
  input  logic [DW-1:0] c_data_i,
  input  logic          ready_i,
  input  logic [1:0]    addr_i,
  output logic [DW-1:0] rdata_o,
  output logic          run_o,
  output logic          sec_wr_o,
  output logic          irq_o
);
  logic [DW-1:0] sec_q, alm_q, trim_q;
  logic hz_f_q, hz_ie_q, al_f_q, al_ie_q, al_en_q, run_q;
  logic ctrl_wr, alm_wr, trim_wr;
  logic [DW-1:0] sec_nxt;
  logic alarm_hit;

  assign ctrl_wr  = commit_i && (c_addr_i == A_CTRL);
  assign sec_wr_o = commit_i && (c_addr_i == A_SEC);
  assign alm_wr   = commit_i && (c_addr_i == A_ALM);
  assign trim_wr  = commit_i && (c_addr_i == A_TRIM);
  assign sec_nxt  = sec_q + 1'b1;
  assign alarm_hit = tick_i && al_en_q && (sec_nxt == alm_q);
  assign run_o    = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q   <= '0;
      alm_q   <= '0;
      trim_q  <= '0;
      hz_f_q  <= 1'b0;
      hz_ie_q <= 1'b0;
      al_f_q  <= 1'b0;
      al_ie_q <= 1'b0;
      al_en_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      if (sec_wr_o)    sec_q <= c_data_i;
      else if (tick_i) sec_q <= sec_nxt;
      if (alm_wr)  alm_q  <= c_data_i;
      if (trim_wr) trim_q <= c_data_i;
      if (ctrl_wr) begin
        hz_ie_q <= c_data_i[B_HZ_IE];
        al_ie_q <= c_data_i[B_AL_IE];
        al_en_q <= c_data_i[B_AL_EN];
        run_q   <= c_data_i[B_RUN];
      end
      // zero clears, one keeps; a new event wins over a clear
      hz_f_q <= tick_i    || (hz_f_q && !(ctrl_wr && !c_data_i[B_HZ_F]));
      al_f_q <= alarm_hit || (al_f_q && !(ctrl_wr && !c_data_i[B_AL_F]));
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (rtc_addr_e'(addr_i))
      A_CTRL: begin
        rdata_o[B_RDY]   = ready_i;
        rdata_o[B_HZ_F]  = hz_f_q;
        rdata_o[B_HZ_IE] = hz_ie_q;
        rdata_o[B_AL_F]  = al_f_q;
        rdata_o[B_AL_IE] = al_ie_q;
        rdata_o[B_AL_EN] = al_en_q;
        rdata_o[B_RUN]   = run_q;
      end
      A_SEC:  rdata_o = sec_q;
      A_ALM:  rdata_o = alm_q;
      A_TRIM: rdata_o = trim_q;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = (hz_f_q && hz_ie_q) || (al_f_q && al_ie_q);

  p_sec_steady_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !sec_wr_o) |=> $stable(sec_q));

  p_no_count_when_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !sec_wr_o) |=> $stable(sec_q));

  p_hz_flag_on_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> hz_f_q);

  p_alarm_needs_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!al_f_q && !al_en_q) |=> !al_f_q);

  p_irq_needs_enable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hz_ie_q && !al_ie_q) |-> !irq_o);
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import rtc_pkg::*;
#(
  parameter int DIV           = 32768,
  parameter int COMMIT_CYCLES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_en_i,
  input  logic [1:0]  addr_i,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  logic          ready, commit, run, sec_wr, tick;
  logic [1:0]    c_addr;
  logic [DW-1:0] c_data;

  rtc_wr_commit #(.LAT(COMMIT_CYCLES)) u_commit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .ready_o  (ready),
    .commit_o (commit),
    .c_addr_o (c_addr),
    .c_data_o (c_data)
  );

  rtc_prescaler #(.DIV(DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .en_i   (tick_en_i),
    .clr_i  (sec_wr),
    .tick_o (tick)
  );

  rtc_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .commit_i (commit),
    .c_addr_i (c_addr),
    .c_data_i (c_data),
    .ready_i  (ready),
    .addr_i   (addr_i),
    .rdata_o  (rdata_o),
    .run_o    (run),
    .sec_wr_o (sec_wr),
    .irq_o    (irq_o)
  );

  p_tick_not_on_sec_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_wr |-> !tick);
endmodule

// File: tb/sec_rtc_bench.sv
module sec_rtc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int LAT = 4;
  localparam int NV  = 7;

  // {addr[1:0], wdata[31:0], expected readback[31:0]}
  localparam logic [65:0] VEC [NV] = '{
    {2'd1, 32'h1234_5678, 32'h1234_5678},
    {2'd2, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {2'd3, 32'h0000_A5A5, 32'h0000_A5A5},
    {2'd0, 32'hFFFF_FFFF, 32'h0000_00AD},
    {2'd0, 32'h0000_0000, 32'h0000_0080},
    {2'd2, 32'h0000_0000, 32'h0000_0000},
    {2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  sec_rtc #(.DIV(DIV), .COMMIT_CYCLES(LAT)) u_sec_rtc (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_en_i (tick_en),
    .addr_i    (addr),
    .wr_i      (wr),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .irq_o     (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_ready();
    logic [31:0] c;
    rd(2'd0, c);
    while (!c[7]) begin
      @(negedge clk);
      rd(2'd0, c);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    wait_ready();
  endtask

  task automatic pulses(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] d;
    int lows;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(2'd0, d); check("R1 ctrl", d, 32'h80);
    rd(2'd1, d); check("R1 sec", d, 0);
    rd(2'd2, d); check("R1 alarm", d, 0);
    rd(2'd3, d); check("R1 trim", d, 0);
    check("R1 irq", {31'd0, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 table walk
    for (int i = 0; i < NV; i++) begin
      wr_reg(VEC[i][65:64], VEC[i][63:32]);
      rd(VEC[i][65:64], d);
      check("R4 readback", d, VEC[i][31:0]);
    end

    // R5 counter disabled: no change
    pulses(2*DIV);
    rd(2'd1, d); check("R5 hold when off", d, 32'hFFFF_FFFF);
    rd(2'd0, d); check("R6 no flag when off", d, 32'h80);

    // R5 enable, one tick wraps; R7 alarm disabled even though 0 == alarm
    wr_reg(2'd0, 32'h01);
    pulses(DIV);
    rd(2'd1, d); check("R5 wrap", d, 0);
    rd(2'd0, d); check("R6 R7 flags", d, 32'hC1);
    check("R8 irq masked", {31'd0, irq}, 0);

    // R6 write 1 keeps flag, R8 irq from second source
    wr_reg(2'd0, 32'h61);
    rd(2'd0, d); check("R6 keep", d, 32'hE1);
    check("R8 irq hz", {31'd0, irq}, 1);
    wr_reg(2'd0, 32'h21);
    rd(2'd0, d); check("R6 clear", d, 32'hA1);
    check("R8 irq cleared", {31'd0, irq}, 0);

    // R7 alarm at 3
    wr_reg(2'd2, 32'd3);
    wr_reg(2'd0, 32'h0D);
    pulses(2*DIV);
    rd(2'd1, d); check("R5 two ticks", d, 2);
    rd(2'd0, d); check("R7 not yet", d, 32'hCD);
    check("R8 irq hz masked", {31'd0, irq}, 0);
    pulses(DIV);
    rd(2'd0, d); check("R7 alarm hit", d, 32'hDD);
    check("R8 irq alarm", {31'd0, irq}, 1);
    wr_reg(2'd0, 32'h4D);
    rd(2'd0, d); check("R7 alarm clear", d, 32'hCD);
    check("R8 irq off", {31'd0, irq}, 0);

    // R9 seconds write resets prescaler phase
    pulses(DIV-1);
    wr_reg(2'd1, 32'd100);
    pulses(DIV-1);
    rd(2'd1, d); check("R9 no early tick", d, 100);
    pulses(1);
    rd(2'd1, d); check("R9 tick after full period", d, 101);
    rd(2'd1, d); check("R10 stable reread", d, 101);

    // R3 write during busy dropped
    @(negedge clk);
    wr = 1'b1; addr = 2'd3; wdata = 32'h11;
    @(negedge clk);
    wdata = 32'h22;
    @(negedge clk);
    wr = 1'b0;
    wait_ready();
    rd(2'd3, d); check("R3 busy write ignored", d, 32'h11);

    // R2 ready low for exactly LAT cycles
    @(negedge clk);
    wr = 1'b1; addr = 2'd3; wdata = 32'h33;
    @(negedge clk);
    wr = 1'b0;
    lows = 0;
    rd(2'd0, d);
    while (!d[7] && lows < 50) begin
      lows++;
      @(negedge clk);
      rd(2'd0, d);
    end
    check("R2 busy cycles", lows, LAT);
    rd(2'd3, d); check("R2 value after ready", d, 32'h33);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule